// File: doc/BRIEF.md
# Consecutive Read Failure Monitor

This block follows a serial read master that polls power-rail telemetry. Each time a read finishes or is given up, the master sends one sample strobe. With it come the rail index, the measurement kind (voltage or current), three bridge status bits, a CRC-ok flag, the slave acknowledge field and the 16-bit reading. The block gives each strobe a pass or fail verdict. It keeps one run-length counter of back-to-back failures for each rail/kind pair, and it latches the reading for a passing read or zero for a failing one.

When a run reaches the limit of eight failures, the block raises a sticky reset request and drops every monitoring enable. The polling period is 500 µs, so a fault that persists is reported within 4 ms. A single-cycle error pulse, with a 2-bit cause code, marks the first failure of a run and the failure that trips the limit. Downstream logging uses this pulse.

Top module: `rd_fault_watch`

## Requirements
- R1: There are four counters, one for each slot. A slot number is rail*2+kind, with kind 0 for voltage and 1 for current. The counter of slot i appears on `cnt_flat[i*4 +: 4]`. A strobe changes only the counter of its own slot.
- R2: A failure gets one cause, taken by priority. Code 0 is a bridge error (write-while-busy or FSM error set). Code 1 is a timeout (busy still set). Code 2 is a CRC mismatch (`crc_ok` low). Code 3 is a nonzero acknowledge.
- R3: Any failure adds one to the counter of the strobe's slot.
- R4: A passing strobe clears the counter of its slot to zero and latches `rd_data_in` onto `rd_val`.
- R5: A failing strobe sets `rd_val` to zero.
- R6: `err_pulse` is high for one cycle only when a failure brings a counter to 1 or to 8. `err_cause` then holds the cause code of R2.
- R7: When a counter reaches 8, `rst_req` goes high and every bit of `mon_en` goes low.
- R8: While `rst_req` is high, strobes are ignored: counters, reading and pulse do not change. Only `rst` clears `rst_req`.
- R9: After reset, all counters are zero, `rd_val` is zero, `err_pulse` and `rst_req` are low, and `mon_en` is all ones. All outputs change on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe: a read has completed or been abandoned |
| smp_rail | input | 1 | Rail index of the read |
| smp_kind | input | 1 | 0 = voltage, 1 = current |
| st_busy | input | 1 | Bridge operation still in progress at sample time |
| st_wr_busy_err | input | 1 | Bridge write-while-busy error |
| st_fsm_err | input | 1 | Bridge state machine error |
| crc_ok | input | 1 | Response CRC matched |
| ack | input | 2 | Slave acknowledge field, 0 = accepted |
| rd_data_in | input | 16 | Reading carried in the response |
| rd_val | output | 16 | Latched reading (zero after a failure) |
| cnt_flat | output | 16 | Four 4-bit failure counters, slot i at bits i*4+3..i*4 |
| err_pulse | output | 1 | Error report strobe |
| err_cause | output | 2 | Cause code of the last reported error |
| rst_req | output | 1 | Sticky reset request |
| mon_en | output | 2 | Monitoring enable, one per rail |

## Verification
The cause priority is tested with stacked faults. The first strobe sets every fault bit at once. Each later strobe removes the highest fault still present. The reported code therefore shows whether the classifier takes the first cause in order or the last one. Passing reads between these strobes restart the run, so every failure is again a first failure and is reported. A failure on one slot next to a pass on another tests that slots do not share a counter. Eight failures in a row on one slot check where the pulse fires and when the reset request trips. A passing read after the trip must change nothing. A final reset shows that only reset clears the request.

// File: rtl/fw_pkg.sv
package fw_pkg;

    localparam int CAUSE_W = 2;

    typedef enum logic [CAUSE_W-1:0] {
        CZ_BRIDGE  = 2'd0,
        CZ_TIMEOUT = 2'd1,
        CZ_CRC     = 2'd2,
        CZ_NACK    = 2'd3
    } cause_e;

    typedef struct packed {
        logic busy;
        logic wr_busy_err;
        logic fsm_err;
    } bstat_t;

    typedef struct packed {
        logic   fail;
        cause_e cause;
    } verdict_t;

    // Prioritised classification of one completed read
    function automatic verdict_t judge(input bstat_t st, input logic crc_ok,
                                       input logic any_nack);
        verdict_t v;
        v.fail  = 1'b1;
        v.cause = CZ_NACK;
        if (st.wr_busy_err || st.fsm_err) begin
            v.cause = CZ_BRIDGE;
        end else if (st.busy) begin
            v.cause = CZ_TIMEOUT;
        end else if (!crc_ok) begin
            v.cause = CZ_CRC;
        end else if (any_nack) begin
            v.cause = CZ_NACK;
        end else begin
            v.fail = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/fw_classify.sv
module fw_classify
    import fw_pkg::*;
#(
    parameter int ACK_W = 2
) (
    input  bstat_t           st,
    input  logic             crc_ok,
    input  logic [ACK_W-1:0] ack,
    output verdict_t         verdict
);
    always_comb begin
        verdict = judge(st, crc_ok, |ack);
    end
endmodule

// File: rtl/fw_strike_bank.sv
module fw_strike_bank #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 4,
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hit,
    input  logic                   fail,
    input  logic [SW-1:0]          slot,
    output logic [SLOTS*CNT_W-1:0] cnt_flat,
    output logic [CNT_W-1:0]       next_cnt
);
    logic [CNT_W-1:0] cnt [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[i] <= '0;
            end else if (hit && (slot == SW'(i))) begin
                cnt[i] <= fail ? cnt[i] + 1'b1 : '0;
            end
        end
        assign cnt_flat[i*CNT_W +: CNT_W] = cnt[i];
    end

    // Value the selected counter takes if the current strobe fails
    assign next_cnt = cnt[slot] + 1'b1;
endmodule

// File: rtl/fw_trip_ctrl.sv
module fw_trip_ctrl
    import fw_pkg::*;
#(
    parameter int RAILS = 2,
    parameter int CNT_W = 4,
    parameter int LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  verdict_t         verdict,
    input  logic [CNT_W-1:0] next_cnt,
    output logic             err_pulse,
    output cause_e           err_cause,
    output logic             rst_req,
    output logic [RAILS-1:0] mon_en
);
    logic reportable;
    logic trip;

    assign reportable = hit && verdict.fail &&
                        ((next_cnt == CNT_W'(1)) || (next_cnt == CNT_W'(LIMIT)));
    assign trip       = hit && verdict.fail && (next_cnt == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse <= 1'b0;
            err_cause <= CZ_BRIDGE;
            rst_req   <= 1'b0;
            mon_en    <= '1;
        end else begin
            err_pulse <= reportable;
            if (reportable) begin
                err_cause <= verdict.cause;
            end
            if (trip) begin
                rst_req <= 1'b1;
                mon_en  <= '0;
            end
        end
    end
endmodule

// File: rtl/rd_fault_watch.sv
module rd_fault_watch
    import fw_pkg::*;
#(
    parameter int RAILS  = 2,
    parameter int KINDS  = 2,
    parameter int LIMIT  = 8,
    parameter int DATA_W = 16,
    parameter int ACK_W  = 2,
    localparam int SLOTS = RAILS * KINDS,
    localparam int CNT_W = $clog2(LIMIT + 1),
    localparam int RW    = (RAILS > 1) ? $clog2(RAILS) : 1,
    localparam int KW    = (KINDS > 1) ? $clog2(KINDS) : 1,
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_vld,
    input  logic [RW-1:0]          smp_rail,
    input  logic [KW-1:0]          smp_kind,
    input  logic                   st_busy,
    input  logic                   st_wr_busy_err,
    input  logic                   st_fsm_err,
    input  logic                   crc_ok,
    input  logic [ACK_W-1:0]       ack,
    input  logic [DATA_W-1:0]      rd_data_in,
    output logic [DATA_W-1:0]      rd_val,
    output logic [SLOTS*CNT_W-1:0] cnt_flat,
    output logic                   err_pulse,
    output logic [CAUSE_W-1:0]     err_cause,
    output logic                   rst_req,
    output logic [RAILS-1:0]       mon_en
);
    bstat_t           st;
    verdict_t         verdict;
    logic             hit;
    logic [SW-1:0]    slot;
    logic [CNT_W-1:0] next_cnt;
    cause_e           cause_q;

    assign st   = '{busy: st_busy, wr_busy_err: st_wr_busy_err, fsm_err: st_fsm_err};
    assign slot = SW'(smp_rail) * SW'(KINDS) + SW'(smp_kind);
    assign hit  = smp_vld && !rst_req && mon_en[smp_rail];

    fw_classify #(.ACK_W(ACK_W)) u_cls (
        .st      (st),
        .crc_ok  (crc_ok),
        .ack     (ack),
        .verdict (verdict)
    );

    fw_strike_bank #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .fail     (verdict.fail),
        .slot     (slot),
        .cnt_flat (cnt_flat),
        .next_cnt (next_cnt)
    );

    fw_trip_ctrl #(.RAILS(RAILS), .CNT_W(CNT_W), .LIMIT(LIMIT)) u_trip (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .verdict   (verdict),
        .next_cnt  (next_cnt),
        .err_pulse (err_pulse),
        .err_cause (cause_q),
        .rst_req   (rst_req),
        .mon_en    (mon_en)
    );

    assign err_cause = cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_val <= '0;
        end else if (hit) begin
            rd_val <= verdict.fail ? '0 : rd_data_in;
        end
    end
endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
    parameter int SLOTS  = 4,
    parameter int CNT_W  = 4,
    parameter int LIMIT  = 8,
    parameter int DATA_W = 16,
    parameter int RAILS  = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   smp_vld,
    input logic                   crc_ok,
    input logic [DATA_W-1:0]      rd_val,
    input logic [SLOTS*CNT_W-1:0] cnt_flat,
    input logic                   err_pulse,
    input logic                   rst_req,
    input logic [RAILS-1:0]       mon_en
);
    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req); // R8

    AST_EN_DROPPED: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (mon_en == '0)); // R7

    AST_FROZEN_AFTER_TRIP: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> ($stable(cnt_flat) && $stable(rd_val) && !err_pulse)); // R8

    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(smp_vld)); // R6

    AST_CRC_FAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !rst_req && !crc_ok) |=> (rd_val == '0)); // R5

    for (genvar i = 0; i < SLOTS; i++) begin : g_lim
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            cnt_flat[i*CNT_W +: CNT_W] <= CNT_W'(LIMIT)); // R3
    end
endmodule

bind rd_fault_watch fw_checker #(
    .SLOTS(SLOTS), .CNT_W(CNT_W), .LIMIT(LIMIT), .DATA_W(DATA_W), .RAILS(RAILS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .crc_ok    (crc_ok),
    .rd_val    (rd_val),
    .cnt_flat  (cnt_flat),
    .err_pulse (err_pulse),
    .rst_req   (rst_req),
    .mon_en    (mon_en)
);

// File: tb/sim_rd_fault_watch.sv
module sim_rd_fault_watch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [0:0]  smp_rail = '0;
    logic [0:0]  smp_kind = '0;
    logic        st_busy = 1'b0, st_wr_busy_err = 1'b0, st_fsm_err = 1'b0;
    logic        crc_ok = 1'b1;
    logic [1:0]  ack = '0;
    logic [15:0] rd_data_in = '0;
    logic [15:0] rd_val;
    logic [15:0] cnt_flat;
    logic        err_pulse;
    logic [1:0]  err_cause;
    logic        rst_req;
    logic [1:0]  mon_en;

    always #2 clk = ~clk;

    rd_fault_watch u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_rail(smp_rail),
        .smp_kind(smp_kind), .st_busy(st_busy), .st_wr_busy_err(st_wr_busy_err),
        .st_fsm_err(st_fsm_err), .crc_ok(crc_ok), .ack(ack),
        .rd_data_in(rd_data_in), .rd_val(rd_val), .cnt_flat(cnt_flat),
        .err_pulse(err_pulse), .err_cause(err_cause), .rst_req(rst_req),
        .mon_en(mon_en)
    );

    typedef struct {
        logic [15:0] v;
        logic [15:0] c;
        logic        p;
        logic [1:0]  cz;
        logic        rq;
        logic [1:0]  en;
        string       tag;
    } exp_t;

    exp_t q[$];
    int nvec = 0;
    int nbad = 0;

    // bench model state
    int          mcnt [4];
    logic        mreq;
    logic [15:0] mval;
    logic [1:0]  mcause;

    function automatic logic [15:0] pack_cnt();
        logic [15:0] r;
        for (int i = 0; i < 4; i++) r[i*4 +: 4] = 4'(mcnt[i]);
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) mcnt[i] = 0;
        mreq = 1'b0; mval = '0; mcause = 2'd0;
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_now(input exp_t e);
        nvec++;
        cmp(e.tag, "rd_val", rd_val, e.v);
        cmp(e.tag, "cnt_flat", cnt_flat, e.c);
        cmp(e.tag, "err_pulse", 16'(err_pulse), 16'(e.p));
        if (e.p) cmp(e.tag, "err_cause", 16'(err_cause), 16'(e.cz));
        cmp(e.tag, "rst_req", 16'(rst_req), 16'(e.rq));
        cmp(e.tag, "mon_en", 16'(mon_en), 16'(e.en));
    endtask

    // monitor: pops one expected item at the negedge after each strobe edge
    always @(negedge clk) begin
        if (q.size() > 0) check_now(q.pop_front());
    end

    // driver: called at a negedge; strobe is sampled at the following posedge
    task automatic strobe(input logic r, input logic k, input logic busy,
                          input logic wb, input logic fsm, input logic cok,
                          input logic [1:0] a, input logic [15:0] d,
                          input string tag);
        exp_t e;
        int   s;
        logic f, pulse;
        logic [1:0] cz;
        smp_rail = r; smp_kind = k; st_busy = busy; st_wr_busy_err = wb;
        st_fsm_err = fsm; crc_ok = cok; ack = a; rd_data_in = d; smp_vld = 1'b1;
        s = int'(r) * 2 + int'(k);
        pulse = 1'b0;
        if (!mreq) begin
            f  = wb | fsm | busy | !cok | (a != 2'd0);
            cz = (wb | fsm) ? 2'd0 : busy ? 2'd1 : !cok ? 2'd2 : 2'd3;
            if (f) begin
                mcnt[s]++;
                mval = '0;
                if (mcnt[s] == 1 || mcnt[s] == 8) begin pulse = 1'b1; mcause = cz; end
                if (mcnt[s] == 8) mreq = 1'b1;
            end else begin
                mcnt[s] = 0;
                mval = d;
            end
        end
        e.v = mval; e.c = pack_cnt(); e.p = pulse; e.cz = mcause;
        e.rq = mreq; e.en = mreq ? 2'b00 : 2'b11; e.tag = tag;
        @(posedge clk);
        q.push_back(e);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic do_reset(input string tag);
        exp_t e;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        e.v = '0; e.c = '0; e.p = 1'b0; e.cz = '0; e.rq = 1'b0; e.en = 2'b11; e.tag = tag;
        check_now(e);
    endtask

    bit done = 1'b0;

    initial begin
        #400000;
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset("R9 reset state");

        // R4: pass latches data, slot 0
        strobe(0, 0, 0, 0, 0, 1, 2'd0, 16'h1234, "R4 pass latch");

        // R2 priority ladder on slot 1, with passes in between to restart the run
        strobe(0, 1, 1, 1, 1, 0, 2'd3, 16'hAAAA, "R2 all faults -> cause 0 (R6 first)");
        strobe(0, 1, 0, 0, 0, 1, 2'd0, 16'h0101, "R4 clear after fail");
        strobe(0, 1, 1, 0, 0, 0, 2'd1, 16'hBBBB, "R2 busy -> cause 1");
        strobe(0, 1, 0, 0, 0, 1, 2'd0, 16'h0202, "R4 clear");
        strobe(0, 1, 0, 0, 0, 0, 2'd2, 16'hCCCC, "R2 crc -> cause 2 (R5 zero)");
        strobe(0, 1, 0, 0, 0, 1, 2'd0, 16'h0303, "R4 clear");
        strobe(0, 1, 0, 0, 0, 1, 2'd2, 16'hDDDD, "R2 nack -> cause 3");
        strobe(0, 1, 0, 0, 0, 1, 2'd1, 16'hDDDD, "R3 second fail no pulse (R6)");

        // R1: slot independence
        strobe(1, 0, 0, 0, 1, 1, 2'd0, 16'h0000, "R1 fail slot 2");
        strobe(1, 1, 0, 0, 0, 1, 2'd0, 16'h5A5A, "R1 pass slot 3 leaves others");

        // R7: eight strikes on slot 3
        for (int i = 0; i < 8; i++)
            strobe(1, 1, 1, 0, 0, 1, 2'd0, 16'hFFFF, "R7 strike run (R3 R6)");

        // R8: ignored after trip
        strobe(0, 0, 0, 0, 0, 1, 2'd0, 16'h7777, "R8 pass ignored after trip");
        strobe(1, 0, 0, 1, 0, 1, 2'd0, 16'h7777, "R8 fail ignored after trip");
        repeat (2) @(negedge clk);
        do_reset("R8 only reset clears request");
        strobe(1, 1, 0, 0, 0, 1, 2'd0, 16'h4321, "R4 pass after re-reset");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule